// File: doc/BRIEF.md
# Multichannel Edge-Programmed PWM Generator

This block drives up to sixteen pulse-width-modulated outputs from a single shared timebase. One prescale counter divides the input clock. Each time it wraps, a period counter advances by one step. Each channel has a pair of compare values, a start step and a stop step, that place its high interval inside the period. The channel also has an enable bit.

Software programs the block through a byte-wide register port. Writes to the timebase and edge registers always land in shadow copies. A static parameter mask marks some channels as synchronous. For these channels, and for the timebase when any channel is synchronous, the shadow contents move into the working copies only at the first period start after software writes 1 to the commit register. Unmasked channels follow their shadow edges at once. Glitch-free reconfiguration of a running waveform therefore needs only a write to the commit register, followed by a poll until that register reads 0.

Top module: `pwmbank_top`

## Requirements
- R1: After reset every output is low, every register reads 0, and the commit register reads 0.
- R2: The output period is (P+1)×(N+1) clocks, where P is the byte at address 0x00 (prescale) and N is the byte at address 0x01 (period length).
- R3: When the start step S is less than the stop step E, a channel is high from step S up to, but not including, step E. The high time is (E−S)×(P+1) clocks. For channel i, S is at address 0x20+2i and E is at address 0x21+2i.
- R4: When S is greater than E, the high interval wraps across the period start. The channel is high at steps ≥S and at steps <E.
- R5: When S equals E, the channel stays low for the whole period.
- R6: With N ≤ 0xFE, S=0 and E=N+1, the output stays high continuously.
- R7: The enable bit for channel i is bit i of address 0x02 for channels 0–7, and bit i−8 of address 0x03 for channels 8–15. A disabled channel drives its output low.
- R8: For a channel in the synchronous mask, new edge values are read back at once. The waveform keeps its old values until the commit register is written and the next period starts.
- R9: For a channel outside the synchronous mask, a new edge value changes the waveform without a commit.
- R10: Writing bit 0 = 1 to address 0x04 makes that register read 1. It returns to 0 by itself once the commit has taken place at a period start.
- R11: The timebase, edge and enable registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Register byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| pwmOut | output | 16 | Channel outputs |

## Verification
A wrong counter wrap, or a timebase loaded at the wrong moment, lengthens or shortens a period. This shows on every enabled output within one period. A pending flag that never clears or never sets shows at the commit register within one period of the write. An active register that loads too early or misses its load shows as a wrong high time on the very next measured pulse of a synchronous channel. The bench therefore measures whole pulses: high time and full period, taken from edge to edge, after each change.

// File: rtl/pwmbank_pkg.sv
package pwmbank_pkg;
  localparam int ADDR_PRE    = 0;
  localparam int ADDR_PER    = 1;
  localparam int ADDR_EN_LO  = 2;
  localparam int ADDR_EN_HI  = 3;
  localparam int ADDR_COMMIT = 4;
  localparam int EDGE_BASE   = 32;

  typedef struct packed {
    logic commitNow;
    logic pending;
  } strobes_t;
endpackage

// File: rtl/pwmbank_ctrl.sv
module pwmbank_ctrl
  import pwmbank_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int W      = 8,
  parameter int ADDR_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [W-1:0]               wrData,
  output logic [W-1:0]               rdData,
  input  logic                       periodEnd,
  output strobes_t                   strb,
  output logic [W-1:0]               preShadow,
  output logic [W-1:0]               perShadow,
  output logic [NUM_CH-1:0][W-1:0]   riseShadow,
  output logic [NUM_CH-1:0][W-1:0]   fallShadow,
  output logic [NUM_CH-1:0]          chEnable
);
  localparam int EN_BITS = 16;

  logic [EN_BITS-1:0] enReg;
  logic               pendingQ;
  logic               commitWrite;

  assign commitWrite = wrEn && (addr == ADDR_W'(ADDR_COMMIT)) && wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preShadow <= '0;
      perShadow <= '0;
      enReg     <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_W'(ADDR_PRE))   preShadow <= wrData;
      if (addr == ADDR_W'(ADDR_PER))   perShadow <= wrData;
      if (addr == ADDR_W'(ADDR_EN_LO)) enReg[7:0]  <= wrData[7:0];
      if (addr == ADDR_W'(ADDR_EN_HI)) enReg[15:8] <= wrData[7:0];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        riseShadow[i] <= '0;
        fallShadow[i] <= '0;
      end else if (wrEn) begin
        if (addr == ADDR_W'(EDGE_BASE + 2*i))     riseShadow[i] <= wrData;
        if (addr == ADDR_W'(EDGE_BASE + 2*i + 1)) fallShadow[i] <= wrData;
      end
    end
  end

  assign chEnable = enReg[NUM_CH-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendingQ <= 1'b0;
    else if (commitWrite)  pendingQ <= 1'b1;
    else if (periodEnd)    pendingQ <= 1'b0;
  end

  assign strb.pending   = pendingQ;
  assign strb.commitNow = pendingQ && periodEnd;

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(ADDR_PRE))    rdData = preShadow;
    if (addr == ADDR_W'(ADDR_PER))    rdData = perShadow;
    if (addr == ADDR_W'(ADDR_EN_LO))  rdData = W'(enReg[7:0]);
    if (addr == ADDR_W'(ADDR_EN_HI))  rdData = W'(enReg[15:8]);
    if (addr == ADDR_W'(ADDR_COMMIT)) rdData = W'(pendingQ);
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(EDGE_BASE + 2*i))     rdData = riseShadow[i];
      if (addr == ADDR_W'(EDGE_BASE + 2*i + 1)) rdData = fallShadow[i];
    end
  end

  // R10: a commit consumed at a period start clears the pending flag
  a_r10_pending_clears: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && periodEnd && !commitWrite) |=> !pendingQ);
  // R10: a commit write always leaves the flag set
  a_r10_pending_sets: assert property (@(posedge clk) disable iff (!rstN)
    commitWrite |=> pendingQ);
endmodule

// File: rtl/pwmbank_datapath.sv
module pwmbank_datapath
  import pwmbank_pkg::*;
#(
  parameter int               NUM_CH    = 16,
  parameter int               W         = 8,
  parameter logic [NUM_CH-1:0] SYNC_MASK = 16'hFF00
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strb,
  input  logic [W-1:0]               preShadow,
  input  logic [W-1:0]               perShadow,
  input  logic [NUM_CH-1:0][W-1:0]   riseShadow,
  input  logic [NUM_CH-1:0][W-1:0]   fallShadow,
  input  logic [NUM_CH-1:0]          chEnable,
  output logic                       periodEnd,
  output logic [NUM_CH-1:0]          pwmOut
);
  localparam bit TIMEBASE_SYNC = (SYNC_MASK != '0);

  logic [W-1:0] preAct, perAct;
  logic [W-1:0] preCnt, stepCnt;
  logic         tick;
  logic [NUM_CH-1:0][W-1:0] riseAct, fallAct;

  if (TIMEBASE_SYNC) begin : g_tb_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        preAct <= '0;
        perAct <= '0;
      end else if (strb.commitNow) begin
        preAct <= preShadow;
        perAct <= perShadow;
      end
    end
  end else begin : g_tb_live
    assign preAct = preShadow;
    assign perAct = perShadow;
  end

  assign tick      = (preCnt >= preAct);
  assign periodEnd = tick && (stepCnt >= perAct);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      stepCnt <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) stepCnt <= (stepCnt >= perAct) ? '0 : stepCnt + 1'b1;
    end
  end

  // R2: after a period end both counters restart from zero
  a_r2_restart: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> (preCnt == '0 && stepCnt == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic level;
    if (SYNC_MASK[i]) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          riseAct[i] <= '0;
          fallAct[i] <= '0;
        end else if (strb.commitNow) begin
          riseAct[i] <= riseShadow[i];
          fallAct[i] <= fallShadow[i];
        end
      end
      // R8: working edges of a synchronous channel move only on a commit
      a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
        !strb.commitNow |=> ($stable(riseAct[i]) && $stable(fallAct[i])));
    end else begin : g_live
      assign riseAct[i] = riseShadow[i];
      assign fallAct[i] = fallShadow[i];
    end

    always_comb begin
      if (riseAct[i] <= fallAct[i])
        level = (stepCnt >= riseAct[i]) && (stepCnt < fallAct[i]);
      else
        level = (stepCnt >= riseAct[i]) || (stepCnt < fallAct[i]);
    end
    assign pwmOut[i] = level && chEnable[i];

    // R7: disabled channel is low
    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
      !chEnable[i] |-> !pwmOut[i]);
    // R5: equal edges never drive high
    a_r5_equal_low: assert property (@(posedge clk) disable iff (!rstN)
      (riseAct[i] == fallAct[i]) |-> !pwmOut[i]);
  end
endmodule

// File: rtl/pwmbank_top.sv
module pwmbank_top
  import pwmbank_pkg::*;
#(
  parameter int                NUM_CH    = 16,
  parameter int                W         = 8,
  parameter int                ADDR_W    = 6,
  parameter logic [NUM_CH-1:0] SYNC_MASK = 16'hFF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wrData,
  output logic [W-1:0]      rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  strobes_t                  strb;
  logic                      periodEnd;
  logic [W-1:0]              preShadow, perShadow;
  logic [NUM_CH-1:0][W-1:0]  riseShadow, fallShadow;
  logic [NUM_CH-1:0]         chEnable;

  pwmbank_ctrl #(.NUM_CH(NUM_CH), .W(W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .periodEnd(periodEnd), .strb(strb),
    .preShadow(preShadow), .perShadow(perShadow),
    .riseShadow(riseShadow), .fallShadow(fallShadow), .chEnable(chEnable)
  );

  pwmbank_datapath #(.NUM_CH(NUM_CH), .W(W), .SYNC_MASK(SYNC_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .preShadow(preShadow), .perShadow(perShadow),
    .riseShadow(riseShadow), .fallShadow(fallShadow), .chEnable(chEnable),
    .periodEnd(periodEnd), .pwmOut(pwmOut)
  );
endmodule

// File: tb/test_pwmbank_top.sv
module test_pwmbank_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [15:0] pwmOut;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwmbank_top i_pwmbank_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 6'(a); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = 6'(a);
    #1 d = int'(rdData);
  endtask

  task automatic measure(input int ch, output int hi, output int tot);
    int n = 0;
    hi = 0; tot = 0;
    while (pwmOut[ch] !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    while (pwmOut[ch] !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
    while (pwmOut[ch] === 1'b1 && n < 3000) begin @(negedge clk); hi++; n++; end
    tot = hi;
    while (pwmOut[ch] === 1'b0 && n < 3000) begin @(negedge clk); tot++; n++; end
  endtask

  task automatic countHigh(input int ch, input int cycles, output int hiCount);
    hiCount = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (pwmOut[ch] === 1'b1) hiCount++;
    end
  endtask

  task automatic commitAndWait();
    int d;
    wr(4, 1);
    for (int k = 0; k < 600; k++) begin
      rd(4, d);
      if (d == 0) break;
    end
  endtask

  task automatic t_reset();
    int d;
    check("R1 outputs", int'(pwmOut), 0);
    rd(0, d); check("R1 prescale", d, 0);
    rd(33, d); check("R1 edge", d, 0);
    rd(4, d); check("R1 commit", d, 0);
  endtask

  task automatic t_setup();
    int d;
    wr(0, 1); wr(1, 9);
    wr(32, 2); wr(33, 7);   // ch0
    wr(34, 8); wr(35, 3);   // ch1 wraps
    wr(36, 5); wr(37, 5);   // ch2 equal
    wr(38, 0); wr(39, 10);  // ch3 full
    wr(40, 1); wr(41, 3);   // ch4 disabled
    wr(48, 1); wr(49, 4);   // ch8 sync
    wr(50, 0); wr(51, 2);   // ch9 disabled
    wr(2, 8'h0F); wr(3, 8'h01);
    rd(1, d);  check("R11 period readback", d, 9);
    rd(34, d); check("R11 edge readback", d, 8);
    rd(3, d);  check("R11 enable readback", d, 1);
    commitAndWait();
  endtask

  task automatic t_shape();
    int hi, tot, h;
    measure(0, hi, tot);
    check("R2 period", tot, 20);
    check("R3 high time", hi, 10);
    measure(1, hi, tot);
    check("R4 wrapped high", hi, 10);
    check("R4 period", tot, 20);
    countHigh(2, 60, h); check("R5 equal edges low", h, 0);
    countHigh(3, 60, h); check("R6 full duty", h, 60);
  endtask

  task automatic t_enable();
    int hi, tot, h;
    countHigh(4, 60, h); check("R7 ch4 disabled", h, 0);
    countHigh(9, 60, h); check("R7 ch9 disabled", h, 0);
    measure(8, hi, tot); check("R7 ch8 enabled high byte", hi, 6);
    wr(2, 8'h0E);
    countHigh(0, 60, h); check("R7 ch0 disabled", h, 0);
    wr(2, 8'h0F);
  endtask

  task automatic t_sync();
    int hi, tot, d;
    wr(49, 6);
    rd(49, d); check("R8 shadow readback", d, 6);
    measure(8, hi, tot); check("R8 old value held", hi, 6);
    measure(8, hi, tot); check("R8 still held", hi, 6);
    wr(4, 1);
    rd(4, d); check("R10 pending reads 1", d, 1);
    repeat (25) @(negedge clk);
    rd(4, d); check("R10 self clear", d, 0);
    measure(8, hi, tot); check("R8 new value after commit", hi, 10);
  endtask

  task automatic t_live();
    int hi, tot;
    wr(33, 9);
    measure(0, hi, tot); check("R9 live edge", hi, 14);
    check("R9 period", tot, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_shape();
    t_enable();
    t_sync();
    t_live();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule